// File: doc/BRIEF.md
# Dual Machine-Cycle Timer / Event Counter

This block holds two independent 16-bit up-counters for a small microcontroller's peripheral set. Each channel can be set up in one of two ways. As a timer it advances once per machine cycle, and a machine cycle is twelve oscillator clocks. As an event counter it advances on each high-to-low change of its external input pin. A run bit starts or freezes each channel. When a channel wraps from its all-ones value back to zero, it raises an overflow flag, and a rising flag produces an interrupt request if that channel's enable bit is set.

Software reaches the block through a byte-wide register port with a single address bus. Address 0 is a control byte that holds four bits per channel. The remaining addresses give the low and high bytes of each counter. The block also outputs its machine-cycle strobe so that neighbouring logic can align to it. External inputs pass through a two-flop synchronizer and are then sampled once per machine cycle. The countable input rate is therefore at most one twenty-fourth of the clock rate.

Top module: `tc_dual`

## Requirements
- R1: `mcyc_stb` is high for exactly one clock in every twelve clocks. A running timer-mode channel increments on the clock edge that ends a cycle in which `mcyc_stb` is high.
- R2: A channel in timer mode (mode bit 0) with its run bit set increments by exactly one per machine cycle.
- R3: A channel in event mode (mode bit 1) with its run bit set increments once for each machine cycle in which its synchronized pin sample is 0 and the previous machine cycle's sample was 1. A high pulse that falls between two samples is not counted. A channel in event mode does not count machine cycles.
- R4: A cleared run bit freezes the count. Setting the run bit again resumes counting from the held value.
- R5: An increment from 0xFFFF gives 0x0000 and sets that channel's overflow flag.
- R6: `irq[i]` goes high for one clock, in the cycle after the flag of channel i goes from 0 to 1, provided its interrupt-enable bit is set. If the enable bit is clear, `irq[i]` stays low.
- R7: A write to the control byte sets or clears the overflow flags directly. Writing a 1 raises the interrupt of R6, and writing a 0 clears the flag.
- R8: A write to a counter byte takes effect in place of any increment in the same cycle. The other byte of that counter keeps its value.
- R9: Reset clears both counters, every control bit and `irq`.
- R10: Register map. Control byte at address 0: bits 0..3 belong to channel 0 and are {run, flag, mode, ie} from LSB up; bits 4..7 hold the same fields for channel 1. Channel 0 low byte is at address 1 and high byte at address 2. Channel 1 low byte is at address 3 and high byte at address 4. Other addresses read 0. The two channels do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 2 | External event inputs, one per channel, asynchronous |
| wr_en | input | 1 | Register write strobe for the byte selected by `addr` |
| addr | input | 3 | Register address for both reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| mcyc_stb | output | 1 | Machine-cycle strobe, one clock in twelve |
| irq | output | 2 | Per-channel interrupt request pulse |

## Verification
The hardest case to reach is a counter-byte write that lands in the very cycle in which an increment is also due. The bench waits for `mcyc_stb` at a falling edge and issues the write at that point, so the write and the increment fall on the same rising edge. The pin-sampling rule is also hard to reach. To test it, the bench starts a short high pulse right after a strobe, so the pulse has cleared the synchronizer before the next sample is taken. Wrap-around is reached by preloading 0xFFFE and running two machine cycles.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int CTL_W  = 4;
  // per-channel control field positions
  localparam int F_RUN  = 0;
  localparam int F_FLAG = 1;
  localparam int F_MODE = 2;
  localparam int F_IE   = 3;

  // increment with carry out in the top bit
  function automatic logic [CNT_W:0] tc_step(input logic [CNT_W-1:0] v);
    return {1'b0, v} + {{CNT_W{1'b0}}, 1'b1};
  endfunction

  // a count event: previous sample high, present sample low
  function automatic logic tc_fall(input logic prev, input logic now);
    return prev & ~now;
  endfunction
endpackage

// File: rtl/tc_cycgen.sv
module tc_cycgen #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic stb
);
  localparam int DW = $clog2(DIV);
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                    div_q <= div_q + 1'b1;
  end

  assign stb = (div_q == LAST);
endmodule

// File: rtl/tc_edge.sv
module tc_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic fall
);
  import tc_pkg::*;

  logic [STAGES-1:0] sync_q;
  logic              samp_q;
  logic              now_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], pin};
  end

  assign now_s = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    samp_q <= 1'b0;
    else if (tick) samp_q <= now_s;
  end

  assign fall = tick & tc_fall(samp_q, now_s);
endmodule

// File: rtl/tc_chan.sv
module tc_chan (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic                     fall,
  input  logic                     ctl_wr,
  input  logic [tc_pkg::CTL_W-1:0] ctl_in,
  input  logic                     lo_wr,
  input  logic                     hi_wr,
  input  logic [tc_pkg::BYTE_W-1:0] wdata,
  output logic [tc_pkg::CNT_W-1:0] cnt,
  output logic [tc_pkg::CTL_W-1:0] ctl,
  output logic                     inc_ev,
  output logic                     wrap_ev,
  output logic                     irq
);
  import tc_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   nxt;
  logic [CTL_W-1:0] ctl_q;
  logic             flag_d;
  logic             byte_wr;

  assign byte_wr = lo_wr | hi_wr;
  assign nxt     = tc_step(cnt_q);
  assign inc_ev  = ctl_q[F_RUN] & (ctl_q[F_MODE] ? fall : tick) & ~byte_wr;
  assign wrap_ev = inc_ev & nxt[CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (lo_wr)  cnt_q[BYTE_W-1:0] <= wdata;
    else if (hi_wr)  cnt_q[CNT_W-1:BYTE_W] <= wdata;
    else if (inc_ev) cnt_q <= nxt[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctl_q <= '0;
    else if (ctl_wr)  ctl_q <= ctl_in;
    else if (wrap_ev) ctl_q[F_FLAG] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_d <= 1'b0;
    else        flag_d <= ctl_q[F_FLAG];
  end

  assign irq = ctl_q[F_IE] & ctl_q[F_FLAG] & ~flag_d;
  assign cnt = cnt_q;
  assign ctl = ctl_q;
endmodule

// File: rtl/tc_dual.sv
module tc_dual #(
  parameter int N_CH    = 2,
  parameter int CYC_DIV = 12,
  parameter int SYNC_N  = 2,
  parameter int ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   ext_pin,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              mcyc_stb,
  output logic [N_CH-1:0]   irq
);
  import tc_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTL = '0;

  logic                        tick;
  logic [N_CH-1:0]             fall;
  logic [N_CH-1:0]             lo_wr, hi_wr;
  logic                        ctl_wr;
  logic [N_CH-1:0][CNT_W-1:0]  cnt;
  logic [N_CH-1:0][CTL_W-1:0]  ctl;
  logic [N_CH-1:0]             inc_ev, wrap_ev;
  logic [N_CH*CTL_W-1:0]       ctl_flat;

  tc_cycgen #(.DIV(CYC_DIV)) u_cyc (.clk(clk), .rst_n(rst_n), .stb(tick));

  assign ctl_wr   = wr_en && (addr == A_CTL);
  assign mcyc_stb = tick;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(1 + 2 * i);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(2 + 2 * i);

    assign lo_wr[i] = wr_en && (addr == A_LO);
    assign hi_wr[i] = wr_en && (addr == A_HI);
    assign ctl_flat[i*CTL_W +: CTL_W] = ctl[i];

    tc_edge #(.STAGES(SYNC_N)) u_edge (
      .clk(clk), .rst_n(rst_n), .tick(tick), .pin(ext_pin[i]), .fall(fall[i])
    );

    tc_chan u_chan (
      .clk(clk), .rst_n(rst_n), .tick(tick), .fall(fall[i]),
      .ctl_wr(ctl_wr), .ctl_in(wr_data[i*CTL_W +: CTL_W]),
      .lo_wr(lo_wr[i]), .hi_wr(hi_wr[i]), .wdata(wr_data),
      .cnt(cnt[i]), .ctl(ctl[i]), .inc_ev(inc_ev[i]), .wrap_ev(wrap_ev[i]),
      .irq(irq[i])
    );
  end

  always_comb begin
    rd_data = '0;
    if (addr == A_CTL) rd_data = 8'(ctl_flat);
    for (int i = 0; i < N_CH; i++) begin
      if (addr == ADDR_W'(1 + 2 * i)) rd_data = cnt[i][BYTE_W-1:0];
      if (addr == ADDR_W'(2 + 2 * i)) rd_data = cnt[i][CNT_W-1:BYTE_W];
    end
  end
endmodule

// File: rtl/tc_dual_chk.sv
module tc_dual_chk #(
  parameter int N_CH    = 2,
  parameter int CYC_DIV = 12
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic                                  mcyc_stb,
  input logic [N_CH-1:0]                       irq,
  input logic [N_CH-1:0][tc_pkg::CTL_W-1:0]    ctl,
  input logic [N_CH-1:0][tc_pkg::CNT_W-1:0]    cnt,
  input logic [N_CH-1:0]                       inc_ev,
  input logic [N_CH-1:0]                       wrap_ev,
  input logic [N_CH-1:0]                       lo_wr,
  input logic [N_CH-1:0]                       hi_wr,
  input logic                                  ctl_wr,
  input logic [7:0]                            wr_data
);
  import tc_pkg::*;
  localparam int GW = $clog2(CYC_DIV + 1);

  logic [GW-1:0] gap;
  logic          seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (mcyc_stb) begin
      gap  <= '0;
      seen <= 1'b1;
    end else begin
      gap  <= gap + 1'b1;
    end
  end

  assert_strobe_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && mcyc_stb) |-> (gap == GW'(CYC_DIV - 1)));

  for (genvar i = 0; i < N_CH; i++) begin : g_a
    assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
      inc_ev[i] |=> (cnt[i] == $past(cnt[i]) + 1'b1));

    assert_frozen_when_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl[i][F_RUN] && !lo_wr[i] && !hi_wr[i]) |=> $stable(cnt[i]));

    assert_wrap_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_ev[i] && !ctl_wr) |=> (ctl[i][F_FLAG] && cnt[i] == '0));

    assert_irq_qualified_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> (ctl[i][F_IE] && ctl[i][F_FLAG]));

    assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |=> !irq[i]);

    assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lo_wr[i] |=> (cnt[i][BYTE_W-1:0] == $past(wr_data)
                    && cnt[i][CNT_W-1:BYTE_W] == $past(cnt[i][CNT_W-1:BYTE_W])));
  end
endmodule

bind tc_dual tc_dual_chk #(.N_CH(N_CH), .CYC_DIV(CYC_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .mcyc_stb(mcyc_stb), .irq(irq), .ctl(ctl),
  .cnt(cnt), .inc_ev(inc_ev), .wrap_ev(wrap_ev), .lo_wr(lo_wr),
  .hi_wr(hi_wr), .ctl_wr(ctl_wr), .wr_data(wr_data)
);

// File: tb/tc_dual_test.sv
`timescale 1ns/1ps
module tc_dual_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ext_pin = 2'b00;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       mcyc_stb;
  logic [1:0] irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  tc_dual uut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .mcyc_stb(mcyc_stb), .irq(irq)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic rd16(input int ch, output int v);
    logic [7:0] lo, hi;
    rd(3'(1 + 2 * ch), lo);
    rd(3'(2 + 2 * ch), hi);
    v = {hi, lo};
  endtask

  // count n strobes from the current falling edge; ends past the edge that applies the last
  task automatic run_mc(input int n);
    int c = 0;
    while (c < n) begin
      if (mcyc_stb) c++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check($sformatf("R9 reset reg %0d", a), d, 0);
    end
    check("R9 reset irq", irq, 0);
  endtask

  task automatic t_strobe;
    int gap = 0;
    while (!mcyc_stb) @(negedge clk);
    @(negedge clk);
    gap = 1;
    while (!mcyc_stb) begin @(negedge clk); gap++; end
    check("R1 strobe period", gap, 12);
  endtask

  task automatic t_timer;
    int v;
    wr(3'd1, 8'h10);
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h01);
    run_mc(5);
    rd16(0, v);
    check("R2 timer five cycles", v, 16'h0015);
    rd16(1, v);
    check("R10 idle channel untouched", v, 0);
  endtask

  task automatic t_freeze;
    int v, w;
    wr(3'd0, 8'h00);
    rd16(0, v);
    run_mc(3);
    rd16(0, w);
    check("R4 frozen", w, v);
    wr(3'd0, 8'h01);
    run_mc(2);
    rd16(0, w);
    check("R4 resumed", w, v + 2);
  endtask

  task automatic t_wrap;
    int v;
    logic [7:0] c;
    wr(3'd0, 8'h00);
    wr(3'd1, 8'hFE);
    wr(3'd2, 8'hFF);
    wr(3'd0, 8'h09);
    run_mc(2);
    rd16(0, v);
    check("R5 wrapped to zero", v, 0);
    check("R6 irq on overflow", irq, 2'b01);
    rd(3'd0, c);
    check("R5 flag set", c, 8'h0B);
    @(negedge clk);
    check("R6 irq one clock", irq, 2'b00);
  endtask

  task automatic t_flag_sw;
    logic [7:0] c;
    wr(3'd0, 8'h08);
    rd(3'd0, c);
    check("R7 flag cleared", c, 8'h08);
    check("R7 no irq on clear", irq, 0);
    wr(3'd0, 8'h0A);
    check("R7 forced irq", irq, 2'b01);
    wr(3'd0, 8'h00);
    wr(3'd0, 8'h02);
    check("R6 no irq when disabled", irq, 0);
    rd(3'd0, c);
    check("R7 flag forced without ie", c, 8'h02);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_events;
    int v;
    wr(3'd0, 8'h50);
    for (int k = 0; k < 3; k++) begin
      ext_pin[1] = 1'b1;
      run_mc(3);
      ext_pin[1] = 1'b0;
      run_mc(3);
    end
    rd16(1, v);
    check("R3 three falling edges", v, 3);
    while (!mcyc_stb) @(negedge clk);
    ext_pin[1] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    ext_pin[1] = 1'b0;
    run_mc(3);
    rd16(1, v);
    check("R3 unsampled pulse ignored", v, 3);
    rd16(0, v);
    check("R10 channel 0 untouched", v, 0);
  endtask

  task automatic t_write_priority;
    int v;
    wr(3'd0, 8'h10);
    wr(3'd4, 8'h12);
    while (!mcyc_stb) @(negedge clk);
    wr(3'd3, 8'h40);
    rd16(1, v);
    check("R8 low write beats increment", v, 16'h1240);
    while (!mcyc_stb) @(negedge clk);
    wr(3'd4, 8'h77);
    rd16(1, v);
    check("R8 high write keeps low", v, 16'h7740);
    run_mc(1);
    rd16(1, v);
    check("R2 channel 1 timer step", v, 16'h7741);
  endtask

  task automatic t_rst_mid;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_strobe();
    t_timer();
    t_freeze();
    t_wrap();
    t_flag_sw();
    t_events();
    t_write_priority();
    t_rst_mid();
    finish_run();
  end
endmodule